// File: doc/BRIEF.md
# Mux-Assisted Unrolled CORDIC Rotator

This block turns a signed angle into its cosine and sine using eight CORDIC micro-rotations in rotation mode. The vector always starts at (1/K, 0). Because of that fixed start, the coordinates after the first three micro-rotations depend only on the three rotation directions. Those three stages are therefore built as an eight-entry constant table, selected by the direction bits. Only the angle residual still needs adders in that region. The remaining five micro-rotations are ordinary shift-and-add datapaths.

Registers after the fourth and seventh micro-rotations, plus an output register, split the datapath into three segments. A valid bit travels alongside the data. A new angle may enter on every clock, and results leave in order three clocks later. The data registers load only when their valid bit is set, so the outputs keep the last result between samples.

Top module: `cordic_rot_mux`

## Requirements
- R1: `out_valid_o` is `in_valid_i` delayed by exactly three rising clock edges. Each result belongs to the angle presented three edges earlier.
- R2: While `rst_ni` is low, `out_valid_o`, `cos_o` and `sin_o` are all 0. An angle accepted shortly before a reset never appears at the output.
- R3: One angle is accepted per clock. Back-to-back and gapped input streams each yield one result per accepted angle, in input order.
- R4: `angle_i` is signed Q2.13 radians and `cos_o` is signed Q1.14. For angles in [-pi/2, pi/2], `cos_o` is within 160 LSB of cos(angle)*16384.
- R5: For the same angles, `sin_o` is within 160 LSB of sin(angle)*16384. The sign of the first micro-rotation follows the angle's sign bit: a non-negative angle rotates counter-clockwise.
- R6: On cycles whose output is not valid, `cos_o` and `sin_o` hold their previous values, whatever `angle_i` does while `in_valid_i` is low.
- R7: The range extends past ±pi/2 up to ±1.70 rad (±13926). There `cos_o` turns negative and both outputs still stay within 160 LSB of the true values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Angle sample present |
| angle_i | input | 16 | Signed angle, Q2.13 radians |
| out_valid_o | output | 1 | Result present |
| cos_o | output | 16 | Cosine, signed Q1.14 |
| sin_o | output | 16 | Sine, signed Q1.14 |

## Verification
The hardest situation to reach is a reset that lands while an accepted angle is still inside the pipeline. The bench gets there by sending one angle and pulling reset low one clock later. It then requires that no result emerges, and that the block accepts a fresh angle cleanly afterwards. The constant table is reached through every one of its eight direction combinations by using angles of both signs, small, mid-range and near the reach limit. Output holding is provoked by wiggling `angle_i` while `in_valid_i` is low.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;
  localparam int XY_W   = 16;  // Q1.14
  localparam int ANG_W  = 16;  // Q2.13 radians
  localparam int N_ITER = 8;
  localparam int N_SEL  = 3;   // leading iterations folded into a constant table
  localparam int SEL_N  = 1 << N_SEL;
  localparam int CUT_A  = 4;   // register after this many iterations
  localparam int CUT_B  = 7;

  typedef logic signed [XY_W-1:0]  xy_t;
  typedef logic signed [ANG_W-1:0] ang_t;
  typedef struct packed {xy_t x; xy_t y;} xy_pair_t;

  localparam xy_t GAIN_INV = 16'sd9949;  // 0.60725 * 2^14

  function automatic ang_t atan_q(input int i);
    case (i)
      0: return 16'sd6434;
      1: return 16'sd3798;
      2: return 16'sd2007;
      3: return 16'sd1019;
      4: return 16'sd511;
      5: return 16'sd256;
      6: return 16'sd128;
      7: return 16'sd64;
      default: return '0;
    endcase
  endfunction

  // bit i of code set = clockwise turn at iteration i
  function automatic xy_pair_t seed_xy(input int code);
    xy_t x, y, xn, yn;
    x = GAIN_INV;
    y = '0;
    for (int i = 0; i < N_SEL; i++) begin
      if (((code >> i) & 1) != 0) begin
        xn = x + (y >>> i);
        yn = y - (x >>> i);
      end else begin
        xn = x - (y >>> i);
        yn = y + (x >>> i);
      end
      x = xn;
      y = yn;
    end
    return '{x: x, y: y};
  endfunction
endpackage

// File: rtl/cordic_const_sel.sv
module cordic_const_sel
  import cordic_rot_pkg::*;
(
  input  ang_t ang_i,
  output xy_t  x_o,
  output xy_t  y_o,
  output ang_t z_o
);
  logic [N_SEL-1:0] cw;
  ang_t z [N_SEL+1];
  xy_t  tbl_x [SEL_N];
  xy_t  tbl_y [SEL_N];

  assign z[0] = ang_i;

  for (genvar g = 0; g < N_SEL; g++) begin : g_res
    assign cw[g]  = z[g][ANG_W-1];
    assign z[g+1] = cw[g] ? z[g] + atan_q(g) : z[g] - atan_q(g);
  end

  for (genvar c = 0; c < SEL_N; c++) begin : g_tbl
    localparam xy_pair_t P = seed_xy(c);
    assign tbl_x[c] = P.x;
    assign tbl_y[c] = P.y;
  end

  assign x_o = tbl_x[cw];
  assign y_o = tbl_y[cw];
  assign z_o = z[N_SEL];
endmodule

// File: rtl/cordic_shift_stage.sv
module cordic_shift_stage
  import cordic_rot_pkg::*;
#(
  parameter int SHIFT = 3
) (
  input  xy_t  x_i,
  input  xy_t  y_i,
  input  ang_t z_i,
  output xy_t  x_o,
  output xy_t  y_o,
  output ang_t z_o
);
  localparam ang_t STEP = atan_q(SHIFT);

  logic cw;
  xy_t  xs, ys;

  assign cw = z_i[ANG_W-1];
  assign xs = x_i >>> SHIFT;
  assign ys = y_i >>> SHIFT;

  always_comb begin
    if (cw) begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + STEP;
    end else begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - STEP;
    end
  end
endmodule

// File: rtl/cordic_pipe_reg.sv
module cordic_pipe_reg #(
  parameter int PW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [PW-1:0] d_i,
  output logic          vld_o,
  output logic [PW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end

  AST_VALID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vld_o == $past(vld_i)));  // R1
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(q_o));  // R6
endmodule

// File: rtl/cordic_rot_mux.sv
module cordic_rot_mux
  import cordic_rot_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [ANG_W-1:0] angle_i,
  output logic                    out_valid_o,
  output logic signed [XY_W-1:0]  cos_o,
  output logic signed [XY_W-1:0]  sin_o
);
  localparam int PW_MID = 2*XY_W + ANG_W;
  localparam int PW_OUT = 2*XY_W;
  localparam int N_MID  = CUT_B - CUT_A;
  localparam int LAST   = N_ITER - 1;

  // segment 1: table stages + first shift-add stage
  xy_t  x3, y3, x4, y4;
  ang_t z3, z4;

  cordic_const_sel i_sel (
    .ang_i (angle_i),
    .x_o   (x3),
    .y_o   (y3),
    .z_o   (z3)
  );

  cordic_shift_stage #(.SHIFT(N_SEL)) i_st3 (
    .x_i (x3), .y_i (y3), .z_i (z3),
    .x_o (x4), .y_o (y4), .z_o (z4)
  );

  logic              va;
  logic [PW_MID-1:0] qa;

  cordic_pipe_reg #(.PW(PW_MID)) i_reg_a (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .vld_i (in_valid_i), .d_i ({x4, y4, z4}),
    .vld_o (va), .q_o (qa)
  );

  // segment 2
  xy_t  xm [N_MID+1];
  xy_t  ym [N_MID+1];
  ang_t zm [N_MID+1];

  assign {xm[0], ym[0], zm[0]} = qa;

  for (genvar g = 0; g < N_MID; g++) begin : g_mid
    cordic_shift_stage #(.SHIFT(CUT_A + g)) i_st (
      .x_i (xm[g]),   .y_i (ym[g]),   .z_i (zm[g]),
      .x_o (xm[g+1]), .y_o (ym[g+1]), .z_o (zm[g+1])
    );
  end

  logic              vb;
  logic [PW_MID-1:0] qb;

  cordic_pipe_reg #(.PW(PW_MID)) i_reg_b (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .vld_i (va), .d_i ({xm[N_MID], ym[N_MID], zm[N_MID]}),
    .vld_o (vb), .q_o (qb)
  );

  // segment 3: last micro-rotation, residual no longer needed
  xy_t  xb, yb, xf, yf;
  ang_t zb;

  assign {xb, yb, zb} = qb;

  always_comb begin
    if (zb[ANG_W-1]) begin
      xf = xb + (yb >>> LAST);
      yf = yb - (xb >>> LAST);
    end else begin
      xf = xb - (yb >>> LAST);
      yf = yb + (xb >>> LAST);
    end
  end

  logic [PW_OUT-1:0] qo;

  cordic_pipe_reg #(.PW(PW_OUT)) i_reg_o (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .vld_i (vb), .d_i ({xf, yf}),
    .vld_o (out_valid_o), .q_o (qo)
  );

  assign {cos_o, sin_o} = qo;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!out_valid_o && cos_o == '0 && sin_o == '0);  // R2
    end
  end

  AST_FIRST_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ((y3 > 0) == !angle_i[ANG_W-1]));  // R5
endmodule

// File: tb/test_cordic_rot_mux.sv
module test_cordic_rot_mux;
  localparam int CLK_PERIOD = 10;
  localparam int TOL   = 160;
  localparam int N_VEC = 14;
  localparam logic signed [15:0] VEC_ANG [N_VEC] = '{
    16'sd0, 16'sd1000, -16'sd1000, 16'sd4289, -16'sd4289, 16'sd6434, 16'sd8579,
    -16'sd8579, 16'sd12000, -16'sd12000, 16'sd12868, -16'sd12868, 16'sd13926, -16'sd13926
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic in_valid_i = 1'b0;
  logic signed [15:0] angle_i = '0;
  logic out_valid_o;
  logic signed [15:0] cos_o, sin_o;

  cordic_rot_mux i_cordic_rot_mux (
    .clk_i, .rst_ni, .in_valid_i, .angle_i, .out_valid_o, .cos_o, .sin_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic signed [15:0] q_ang [64];
  int q_cyc [64];
  int wr = 0, rd = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic signed [15:0] a);
    @(negedge clk_i);
    in_valid_i = v;
    angle_i = a;
    if (v) begin
      q_ang[wr % 64] = a;
      q_cyc[wr % 64] = cyc;
      wr++;
    end
  endtask

  // result monitor
  always @(negedge clk_i) begin : mon
    real ar;
    int ec, es;
    bit wide;
    if (rst_ni && out_valid_o) begin
      if (rd == wr) check(1'b0, "R1 unexpected out_valid", 1, 0);
      else begin
        ar = real'(q_ang[rd % 64]) / 8192.0;
        ec = $rtoi($cos(ar) * 16384.0);
        es = $rtoi($sin(ar) * 16384.0);
        wide = iabs(int'(q_ang[rd % 64])) > 12868;
        check(iabs(int'(cos_o) - ec) <= TOL, wide ? "R7 cos" : "R4 cos", cos_o, ec);
        check(iabs(int'(sin_o) - es) <= TOL, wide ? "R7 sin" : "R5 sin", sin_o, es);
        check(cyc - q_cyc[rd % 64] == 3, "R1 latency", cyc - q_cyc[rd % 64], 3);
        rd++;
      end
    end
  end

  initial begin : wdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic signed [15:0] hc, hs;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 1'b0, "R2 reset valid", out_valid_o, 0);
    check(cos_o == 0 && sin_o == 0, "R2 reset data", cos_o, 0);
    rst_ni = 1'b1;

    // back-to-back table walk, R3
    for (int i = 0; i < N_VEC; i++) drive(1'b1, VEC_ANG[i]);
    drive(1'b0, '0);
    repeat (5) @(negedge clk_i);
    check(rd == N_VEC, "R3 back-to-back count", rd, N_VEC);

    // gapped stream, R3
    drive(1'b1, 16'sd2000);
    drive(1'b0, 16'sd7000);
    drive(1'b1, -16'sd3000);
    drive(1'b0, '0);
    drive(1'b1, 16'sd10500);
    drive(1'b0, '0);
    repeat (5) @(negedge clk_i);
    check(rd == wr, "R3 gapped count", rd, wr);

    // hold while idle, R6
    hc = cos_o;
    hs = sin_o;
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 16'sd9000 + 16'(k * 700));
      check(out_valid_o == 1'b0, "R6 idle valid", out_valid_o, 0);
      check(cos_o == hc && sin_o == hs, "R6 hold", cos_o, hc);
    end

    // reset with a sample in flight, R2
    drive(1'b1, 16'sd5000);
    drive(1'b0, '0);
    rst_ni = 1'b0;
    #1;
    check(out_valid_o == 1'b0 && cos_o == 0, "R2 mid-run reset", cos_o, 0);
    @(negedge clk_i);
    wr = rd;
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      check(out_valid_o == 1'b0, "R2 flushed sample", out_valid_o, 0);
    end
    drive(1'b1, 16'sd4289);
    drive(1'b0, '0);
    repeat (5) @(negedge clk_i);
    check(rd == wr, "R2 recovery count", rd, wr);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule